// File: doc/BRIEF.md
# Request Timeout and Duration Meter

This unit sits beside a request sequencer and watches one request at a time. A one-cycle start strobe opens a request and a one-cycle done strobe closes it. While a request is open, a coarse timer counts elapsed clocks in units of 256. If the programmed limit is reached before the done strobe, the timer raises a one-cycle timeout pulse that the interrupt logic can capture.

In parallel, a duration meter counts the same clocks through a prescaler that divides by 2^N. N is a programmable exponent from 0 to 31. The meter's result stays readable after the request ends, so software can recover the real length as count × 2^N. If the 16-bit result would overflow, it saturates at all ones and a sticky overrun flag is set.

The limit and the exponent come from register fields. Both are latched at the start strobe. A limit of zero turns the timeout off. A sensible reset value for the limit field is 37500, which at a 19.2 MHz clock gives 37500 × 256 cycles, about 500 ms.

Top module: `rtm_top`

## Requirements
- R1: After reset, timeoutPulse, busy, durCount and durOverrun are all 0.
- R2: A start strobe clears the duration count and the overrun flag, and restarts the timers, even while a request is open. It also latches limitIn and expIn. Later changes to those inputs have no effect on the open request.
- R3: With a latched limit L > 0, timeoutPulse is high for exactly one cycle, right after the 256·L-th rising edge that follows the start edge. It fires only if done was not sampled on or before that edge.
- R4: The timeout fires at most once per request. A done strobe after the timeout does not produce or cancel any timeout event.
- R5: A latched limit of 0 never produces a timeout, however long the request lasts.
- R6: If done is sampled on the k-th rising edge after the start edge, durCount becomes floor(k / 2^E) from the next cycle, where E is the latched exponent.
- R7: When floor(k / 2^E) exceeds 65535, durCount holds 65535 and durOverrun is 1. Both keep these values until the next start.
- R8: After a request ends, durCount and durOverrun hold their values and no timeout pulse occurs. Extra done strobes and changes to the limit and exponent inputs have no effect until the next start.
- R9: When start and done are sampled on the same edge, start wins and a request opens.
- R10: busy is 1 from the cycle after the start edge through the cycle in which done is sampled, and 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqStart | input | 1 | Request-start strobe from the sequencer |
| reqDone | input | 1 | Request-done strobe from the sequencer |
| limitIn | input | 20 | Timeout limit in units of 256 clocks; 0 disables |
| expIn | input | 5 | Duration prescale exponent E (divide by 2^E) |
| timeoutPulse | output | 1 | One-cycle timeout event |
| busy | output | 1 | A request is open |
| durCount | output | 16 | Measured duration in units of 2^E clocks |
| durOverrun | output | 1 | Sticky duration saturation flag |

## Verification
The embedded properties check, on every cycle, several invariants. The timeout pulse is never repeated within one request and never appears without an open request. The count is all ones whenever overrun is set. A start always leaves zeros and an open request. The count moves by at most one per cycle and stays frozen while the block is idle. Only the bench scenarios can show the exact cycle of the timeout. The same holds for the quotient floor(k/2^E) at the end of a request, suppression when done lands on the expiry edge, and the effect of inputs changed mid-request. The bench sweeps limits, exponents and lengths to cover these, with directed cases for restart, start-with-done and a real 16-bit overrun.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
  // Suggested reset value of the limit field: about 500 ms at 19.2 MHz with 256-clock units
  localparam int unsigned LIMIT_RESET_VALUE = 37500;

  typedef struct packed {
    logic clear;  // start strobe: zero counters, latch configuration
    logic count;  // request open: advance counters this edge
  } rtmStrobe_t;
endpackage

// File: rtl/rtm_ctrl.sv
module rtm_ctrl
  import rtm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqStart,
  input  logic       reqDone,
  input  logic       expire,
  output rtmStrobe_t stb,
  output logic       busy,
  output logic       timeoutPulse
);
  logic fired;

  always_comb begin
    stb.clear = reqStart;
    stb.count = busy && !reqStart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy         <= 1'b0;
      fired        <= 1'b0;
      timeoutPulse <= 1'b0;
    end else if (reqStart) begin
      busy         <= 1'b1;
      fired        <= 1'b0;
      timeoutPulse <= 1'b0;
    end else if (busy) begin
      timeoutPulse <= expire && !fired && !reqDone;
      if (expire && !reqDone) fired <= 1'b1;
      if (reqDone) busy <= 1'b0;
    end else begin
      timeoutPulse <= 1'b0;
    end
  end

  // R4
  once_per_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    fired && !reqStart |=> !timeoutPulse);
  // R3
  pulse_in_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |-> ($past(busy) && fired));
  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |=> !timeoutPulse);
  // R10
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && reqDone && !reqStart |=> !busy);
  // R9
  start_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqStart |=> busy);
endmodule

// File: rtl/rtm_datapath.sv
module rtm_datapath
  import rtm_pkg::*;
#(
  parameter int LIMIT_W    = 20,
  parameter int TICK_SHIFT = 8,
  parameter int DUR_W      = 16,
  parameter int EXP_W      = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  rtmStrobe_t         stb,
  input  logic [LIMIT_W-1:0] limitIn,
  input  logic [EXP_W-1:0]   expIn,
  output logic               expire,
  output logic [DUR_W-1:0]   durCount,
  output logic               durOverrun
);
  localparam int DIV_W = (1 << EXP_W) - 1;

  logic [TICK_SHIFT-1:0] tickCnt;
  logic [LIMIT_W-1:0]    unitCnt;
  logic [LIMIT_W-1:0]    limitHeld;
  logic [EXP_W-1:0]      expHeld;
  logic [DIV_W-1:0]      divCnt;
  logic [DIV_W-1:0]      divMask;
  logic                  unitTick;
  logic                  durTick;

  always_comb begin
    unitTick = &tickCnt;
    divMask  = DIV_W'((64'd1 << expHeld) - 64'd1);
    durTick  = ((divCnt & divMask) == divMask);
    expire   = stb.count && unitTick && (limitHeld != '0) &&
               ((unitCnt + LIMIT_W'(1)) == limitHeld);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt    <= '0;
      unitCnt    <= '0;
      limitHeld  <= '0;
      expHeld    <= '0;
      divCnt     <= '0;
      durCount   <= '0;
      durOverrun <= 1'b0;
    end else if (stb.clear) begin
      tickCnt    <= '0;
      unitCnt    <= '0;
      divCnt     <= '0;
      durCount   <= '0;
      durOverrun <= 1'b0;
      limitHeld  <= limitIn;
      expHeld    <= expIn;
    end else if (stb.count) begin
      tickCnt <= tickCnt + TICK_SHIFT'(1);
      divCnt  <= divCnt + DIV_W'(1);
      if (unitTick) unitCnt <= unitCnt + LIMIT_W'(1);
      if (durTick) begin
        if (&durCount) durOverrun <= 1'b1;
        else           durCount   <= durCount + DUR_W'(1);
      end
    end
  end

  // R7
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    durOverrun |-> (&durCount));
  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> (durCount == '0 && !durOverrun));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.clear && !stb.count |=> ($stable(durCount) && $stable(durOverrun)));
  // R6
  step_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.count |=> (durCount == $past(durCount) ||
                   durCount == $past(durCount) + DUR_W'(1)));
endmodule

// File: rtl/rtm_top.sv
module rtm_top
  import rtm_pkg::*;
#(
  parameter int LIMIT_W    = 20,
  parameter int TICK_SHIFT = 8,
  parameter int DUR_W      = 16,
  parameter int EXP_W      = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqStart,
  input  logic               reqDone,
  input  logic [LIMIT_W-1:0] limitIn,
  input  logic [EXP_W-1:0]   expIn,
  output logic               timeoutPulse,
  output logic               busy,
  output logic [DUR_W-1:0]   durCount,
  output logic               durOverrun
);
  rtmStrobe_t stb;
  logic       expire;

  rtm_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqStart     (reqStart),
    .reqDone      (reqDone),
    .expire       (expire),
    .stb          (stb),
    .busy         (busy),
    .timeoutPulse (timeoutPulse)
  );

  rtm_datapath #(
    .LIMIT_W    (LIMIT_W),
    .TICK_SHIFT (TICK_SHIFT),
    .DUR_W      (DUR_W),
    .EXP_W      (EXP_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .limitIn    (limitIn),
    .expIn      (expIn),
    .expire     (expire),
    .durCount   (durCount),
    .durOverrun (durOverrun)
  );
endmodule

// File: tb/rtm_top_tb.sv
module rtm_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqStart = 1'b0;
  logic        reqDone = 1'b0;
  logic [19:0] limitIn = '0;
  logic [4:0]  expIn = '0;
  logic        timeoutPulse, busy, durOverrun;
  logic [15:0] durCount;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rtm_top u_dut (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqDone(reqDone),
    .limitIn(limitIn), .expIn(expIn), .timeoutPulse(timeoutPulse),
    .busy(busy), .durCount(durCount), .durOverrun(durOverrun)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint quot(input longint k, input int e);
    return k >> e;
  endfunction

  function automatic longint expCount(input longint k, input int e);
    return (quot(k, e) > 65535) ? 65535 : quot(k, e);
  endfunction

  function automatic longint expOver(input longint k, input int e);
    return (quot(k, e) > 65535) ? 1 : 0;
  endfunction

  function automatic longint expPulses(input longint lim, input longint k, input bit doDone);
    if (lim == 0) return 0;
    if (256 * lim < k) return 1;
    if (!doDone && 256 * lim <= k) return 1;
    return 0;
  endfunction

  // One request: start edge, then k edges, done sampled on edge k when doDone
  task automatic runReq(input int lim, input int e, input int k, input bit doDone,
                        input bit doneWithStart, input string tag);
    int pulses = 0;
    longint pulseEdge = -1;
    longint wantPulses;
    logic [15:0] heldCount;
    logic heldOver;
    limitIn = 20'(lim);
    expIn   = 5'(e);
    @(negedge clk);
    reqStart = 1'b1;
    reqDone  = doneWithStart;
    @(negedge clk);
    reqStart = 1'b0;
    for (int j = 1; j <= k; j++) begin
      reqDone = doDone && (j == k);
      if (j == 1) begin
        limitIn = 20'($urandom_range(1, 3));  // R2: later input changes ignored
        expIn   = 5'($urandom_range(0, 31));
      end
      @(negedge clk);
      if (timeoutPulse) begin
        pulses++;
        pulseEdge = j;
      end
      if (j == 1 || j == k)
        check({tag, " R10 busy"}, busy, (j < k || !doDone) ? 1 : 0);
    end
    reqDone = 1'b0;
    wantPulses = expPulses(lim, k, doDone);
    check({tag, (lim == 0) ? " R5 pulses" : " R3 R4 pulses"}, pulses, wantPulses);
    if (wantPulses == 1) check({tag, " R3 pulse edge"}, pulseEdge, 256 * lim);
    if (doDone) begin
      check({tag, " R6 count"}, durCount, expCount(k, e));
      check({tag, " R7 overrun"}, durOverrun, expOver(k, e));
      heldCount = durCount;
      heldOver  = durOverrun;
      pulses = 0;
      for (int j = 0; j < 10; j++) begin
        reqDone = 1'($urandom_range(0, 1));
        limitIn = 20'($urandom_range(0, 2));
        expIn   = 5'($urandom_range(0, 31));
        @(negedge clk);
        if (timeoutPulse) pulses++;
      end
      reqDone = 1'b0;
      check({tag, " R8 count held"}, durCount, heldCount);
      check({tag, " R8 overrun held"}, durOverrun, heldOver);
      check({tag, " R8 no pulse idle"}, pulses, 0);
      check({tag, " R10 idle busy"}, busy, 0);
    end
  endtask

  initial begin
    int unsigned seedSink;
    seedSink = $urandom(32'd20240);
    repeat (3) @(negedge clk);
    check("R1 timeoutPulse", timeoutPulse, 0);
    check("R1 busy", busy, 0);
    check("R1 durCount", durCount, 0);
    check("R1 durOverrun", durOverrun, 0);
    rstN = 1'b1;
    @(negedge clk);

    runReq(2, 0, 300, 1, 0, "short");
    runReq(1, 3, 1000, 1, 0, "late done");         // R4: done after timeout
    runReq(0, 4, 3000, 1, 0, "disabled");          // R5
    runReq(2, 0, 512, 1, 0, "done on expiry");     // R3 boundary
    runReq(2, 0, 513, 1, 0, "one past expiry");
    runReq(1, 2, 200, 0, 0, "open");               // left open
    runReq(1, 1, 300, 1, 0, "R2 restart");
    runReq(0, 0, 50, 1, 1, "R9 start with done");
    runReq(0, 0, 65540, 1, 0, "R7 saturate");
    runReq(0, 1, 4000, 1, 0, "exp one");
    runReq(0, 5, 31, 1, 0, "below one unit");

    for (int i = 0; i < 25; i++) begin
      runReq(int'($urandom_range(0, 6)), int'($urandom_range(0, 7)),
             int'($urandom_range(1, 1500)), 1, 0, "random");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule